// File: doc/BRIEF.md
# Supply and Watchdog Reset Sequencer

This block merges three reset requests into one core reset for a small controller: a low-supply comparator, a deeper brown-out comparator and a watchdog rollover request. Both comparator outputs arrive as digital levels. They are brought into the clock domain through a two-stage synchronizer before the sequencer acts on them. A supply-based reset holds the core until the supply has recovered. It then runs a startup delay of a programmable number of cycles. A watchdog reset holds the core for a fixed number of cycles and does not run the startup delay.

The block also owns a small amount of reset-related control state. A firmware bit disables the low-supply monitor. Suspend mode masks that monitor, and the mask goes away when suspend ends. A brown-out forces the monitor back on. The block keeps an external-oscillator enable and a clock-source select. A supply reset falls back to the internal clock at once. A watchdog reset only clears the enable, and the clock source changes at the next entry into suspend. Two cause flags record which kind of reset last happened, and firmware clears them by writing ones.

While the core reset is high, the pins are tristated through a dedicated enable.

Top module: `supply_reset_seq`

## Requirements
- R1: While `arst_n` is low: `core_rst` and `pin_hiz` are 1, `cause_supply` is 1, and `cause_wdt`, `lvd_dis_o`, `xosc_en_o` and `clk_sel_ext` are 0.
- R2: The low-supply input takes effect when its synchronized level is high, the monitor is enabled and `suspend_i` is low. It then raises `core_rst` at the third rising edge after the input rises. The input has no effect while the monitor is disabled or suspended. A low-supply level still present when suspend ends raises `core_rst` at the next edge.
- R3: The brown-out input acts at all times, including during suspend and when the monitor is disabled. It raises `core_rst` at the third edge, sets `cause_supply`, and clears `lvd_dis_o`.
- R4: After a supply reset, `core_rst` stays high while brown-out is present or while low-supply is present with the monitor enabled. After both are gone, `core_rst` stays high for `STARTUP_CYC` more cycles. A supply fault during that delay restarts the hold, so release comes only after a full delay.
- R5: A one-cycle `wdt_req` while running raises `core_rst` at the next edge and sets `cause_wdt`. `core_rst` is released `WDT_HOLD_CYC` cycles later with no startup delay. A supply fault during this hold turns it into a supply reset.
- R6: On entry to a supply reset, `xosc_en_o` and `clk_sel_ext` both go to 0. A configuration write with bit 1 set makes `xosc_en_o` and `clk_sel_ext` 1 at the next edge.
- R7: A watchdog reset clears `xosc_en_o` and leaves `clk_sel_ext` unchanged. On the next rise of `suspend_i` while running, `clk_sel_ext` takes the value of `xosc_en_o`.
- R8: `pin_hiz` equals `core_rst` in every cycle.
- R9: A status write clears `cause_supply` when data bit 0 is 1 and clears `cause_wdt` when data bit 1 is 1. A cause event in the same cycle wins over the clear.
- R10: A configuration write loads `lvd_dis_o` from data bit 0 and `xosc_en_o` from data bit 1. A brown-out overrides bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| lv_low_raw | input | 1 | Low-supply comparator level, 1 = supply low |
| bo_low_raw | input | 1 | Brown-out comparator level, 1 = supply below brown-out trip |
| wdt_req | input | 1 | Watchdog rollover request, one-cycle pulse |
| suspend_i | input | 1 | Suspend mode active |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 2 | Bit 0 monitor disable, bit 1 external oscillator enable |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 2 | Write-one-to-clear: bit 0 supply cause, bit 1 watchdog cause |
| core_rst | output | 1 | Core reset, active high |
| pin_hiz | output | 1 | Tristate enable for the I/O pins |
| clk_sel_ext | output | 1 | 1 selects the external oscillator as clock source |
| xosc_en_o | output | 1 | External oscillator enable bit |
| lvd_dis_o | output | 1 | Low-supply monitor disable bit |
| cause_supply | output | 1 | A low-supply or brown-out reset has occurred |
| cause_wdt | output | 1 | A watchdog reset has occurred |

## Verification
The sequencer state cannot be seen directly, but each wrong state shows at the ports within a bounded number of cycles. A missed or spurious transition into the supply hold changes `core_rst` and clears `clk_sel_ext` three edges after the comparator input moves. A wrong delay count moves the falling edge of `core_rst` by exactly the error in cycles. A monitor that is wrongly masked, or wrongly left unmasked, shows as a reset that is missing, or that appears when it should not, either three cycles after the input or one cycle after suspend drops. Faults in the cause and clock bits show on the cycle after the event or the write that should have changed them.

// File: rtl/rs_seq_pkg.sv
package rs_seq_pkg;

  typedef enum logic [1:0] {
    IDLE_RUN        = 2'd0,
    HOLD_LOW_SUPPLY = 2'd1,
    STARTUP_DELAY   = 2'd2,
    WDT_HOLD        = 2'd3
  } seq_state_t;

  // configuration write data bit positions
  localparam int CFG_LVD_DIS_BIT = 0;
  localparam int CFG_XOSC_BIT    = 1;
  // status write-one-to-clear bit positions
  localparam int ST_SUPPLY_BIT   = 0;
  localparam int ST_WDT_BIT      = 1;

  // a timed state of lim cycles ends when the count reaches lim-1
  function automatic logic count_done(input logic [31:0] cnt, input logic [31:0] lim);
    return (cnt + 32'd1) >= lim;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) sh <= '0;
      else         sh <= {sh[STAGES-2:0], d[b]};
    end
    assign q[b] = sh[STAGES-1];
  end

endmodule

// File: rtl/rs_sequencer.sv
module rs_sequencer
  import rs_seq_pkg::*;
#(
  parameter int STARTUP_CYC  = 16,
  parameter int WDT_HOLD_CYC = 32
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       lv_s,
  input  logic       bo_s,
  input  logic       lvd_dis,
  input  logic       suspend_i,
  input  logic       wdt_req,
  output seq_state_t state_o,
  output logic       supply_trip,
  output logic       wdt_trip
);

  localparam int unsigned MAXC = max2(STARTUP_CYC, WDT_HOLD_CYC);
  localparam int CW = $clog2(MAXC + 1);

  seq_state_t state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic lv_fault, run_fault, hold_fault, startup_end, wdt_end;

  assign lv_fault    = lv_s & ~lvd_dis;
  assign run_fault   = bo_s | (lv_fault & ~suspend_i);
  assign hold_fault  = bo_s | lv_fault;
  assign startup_end = count_done(32'(cnt_q), 32'(STARTUP_CYC));
  assign wdt_end     = count_done(32'(cnt_q), 32'(WDT_HOLD_CYC));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      IDLE_RUN: begin
        if (run_fault)    state_d = HOLD_LOW_SUPPLY;
        else if (wdt_req) state_d = WDT_HOLD;
      end
      HOLD_LOW_SUPPLY: begin
        if (!hold_fault) state_d = STARTUP_DELAY;
      end
      STARTUP_DELAY: begin
        if (hold_fault)       state_d = HOLD_LOW_SUPPLY;
        else if (startup_end) state_d = IDLE_RUN;
      end
      WDT_HOLD: begin
        if (hold_fault)   state_d = HOLD_LOW_SUPPLY;
        else if (wdt_end) state_d = IDLE_RUN;
      end
      default: state_d = HOLD_LOW_SUPPLY;
    endcase
  end

  assign supply_trip = (state_d == HOLD_LOW_SUPPLY) && (state_q != HOLD_LOW_SUPPLY);
  assign wdt_trip    = (state_q == IDLE_RUN) && (state_d == WDT_HOLD);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= HOLD_LOW_SUPPLY;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q)
        cnt_q <= '0;
      else if (state_q == STARTUP_DELAY || state_q == WDT_HOLD)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/rs_ctrl_regs.sv
module rs_ctrl_regs
  import rs_seq_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_wdata,
  input  logic       stat_wr,
  input  logic [1:0] stat_wdata,
  input  logic       bo_s,
  input  logic       supply_trip,
  input  logic       wdt_trip,
  input  logic       susp_enter,
  output logic       lvd_dis,
  output logic       xosc_en,
  output logic       clk_ext,
  output logic       cause_supply,
  output logic       cause_wdt
);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      lvd_dis      <= 1'b0;
      xosc_en      <= 1'b0;
      clk_ext      <= 1'b0;
      cause_supply <= 1'b1;
      cause_wdt    <= 1'b0;
    end else begin
      // monitor disable: brown-out forces the monitor back on
      if (bo_s)        lvd_dis <= 1'b0;
      else if (cfg_wr) lvd_dis <= cfg_wdata[CFG_LVD_DIS_BIT];

      // oscillator enable: cleared by any reset entry
      if (supply_trip || wdt_trip) xosc_en <= 1'b0;
      else if (cfg_wr)             xosc_en <= cfg_wdata[CFG_XOSC_BIT];

      // clock source: supply reset falls back at once, otherwise a
      // cleared enable is only applied on suspend entry
      if (supply_trip)                          clk_ext <= 1'b0;
      else if (cfg_wr && cfg_wdata[CFG_XOSC_BIT]) clk_ext <= 1'b1;
      else if (susp_enter)                      clk_ext <= xosc_en;

      if (supply_trip)                             cause_supply <= 1'b1;
      else if (stat_wr && stat_wdata[ST_SUPPLY_BIT]) cause_supply <= 1'b0;

      if (wdt_trip)                               cause_wdt <= 1'b1;
      else if (stat_wr && stat_wdata[ST_WDT_BIT]) cause_wdt <= 1'b0;
    end
  end

endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
  import rs_seq_pkg::*;
#(
  parameter int STARTUP_CYC  = 16,
  parameter int WDT_HOLD_CYC = 32,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       lv_low_raw,
  input  logic       bo_low_raw,
  input  logic       wdt_req,
  input  logic       suspend_i,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_wdata,
  input  logic       stat_wr,
  input  logic [1:0] stat_wdata,
  output logic       core_rst,
  output logic       pin_hiz,
  output logic       clk_sel_ext,
  output logic       xosc_en_o,
  output logic       lvd_dis_o,
  output logic       cause_supply,
  output logic       cause_wdt
);

  logic [1:0] sync_q;
  logic       lv_s, bo_s;
  logic       supply_trip, wdt_trip, susp_enter, susp_q;
  logic       in_run, in_startup, in_wdt;
  seq_state_t state;

  rs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .d      ({bo_low_raw, lv_low_raw}),
    .q      (sync_q)
  );
  assign lv_s = sync_q[0];
  assign bo_s = sync_q[1];

  rs_sequencer #(.STARTUP_CYC(STARTUP_CYC), .WDT_HOLD_CYC(WDT_HOLD_CYC)) u_seq (
    .clk         (clk),
    .arst_n      (arst_n),
    .lv_s        (lv_s),
    .bo_s        (bo_s),
    .lvd_dis     (lvd_dis_o),
    .suspend_i   (suspend_i),
    .wdt_req     (wdt_req),
    .state_o     (state),
    .supply_trip (supply_trip),
    .wdt_trip    (wdt_trip)
  );

  assign in_run     = (state == IDLE_RUN);
  assign in_startup = (state == STARTUP_DELAY);
  assign in_wdt     = (state == WDT_HOLD);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) susp_q <= 1'b0;
    else         susp_q <= suspend_i;
  end
  assign susp_enter = suspend_i & ~susp_q & in_run;

  rs_ctrl_regs u_regs (
    .clk          (clk),
    .arst_n       (arst_n),
    .cfg_wr       (cfg_wr),
    .cfg_wdata    (cfg_wdata),
    .stat_wr      (stat_wr),
    .stat_wdata   (stat_wdata),
    .bo_s         (bo_s),
    .supply_trip  (supply_trip),
    .wdt_trip     (wdt_trip),
    .susp_enter   (susp_enter),
    .lvd_dis      (lvd_dis_o),
    .xosc_en      (xosc_en_o),
    .clk_ext      (clk_sel_ext),
    .cause_supply (cause_supply),
    .cause_wdt    (cause_wdt)
  );

  assign core_rst = ~in_run;
  assign pin_hiz  = core_rst;

endmodule

// File: rtl/rs_checker.sv
module rs_checker (
  input logic clk,
  input logic arst_n,
  input logic core_rst,
  input logic suspend_i,
  input logic wdt_req,
  input logic cfg_wr,
  input logic bo_s,
  input logic supply_trip,
  input logic wdt_trip,
  input logic susp_enter,
  input logic in_run,
  input logic in_startup,
  input logic in_wdt,
  input logic lvd_dis_o,
  input logic xosc_en_o,
  input logic clk_sel_ext,
  input logic cause_wdt
);

  assert_susp_mask_R2: assert property (@(posedge clk) disable iff (!arst_n)
    (in_run && suspend_i && !bo_s && !wdt_req) |=> !core_rst);

  assert_bo_reenable_R3: assert property (@(posedge clk) disable iff (!arst_n)
    bo_s |=> !lvd_dis_o);

  assert_bo_resets_R3: assert property (@(posedge clk) disable iff (!arst_n)
    bo_s |=> core_rst);

  assert_release_path_R4: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(core_rst) |-> ($past(in_startup) || $past(in_wdt)));

  assert_wdt_entry_R5: assert property (@(posedge clk) disable iff (!arst_n)
    wdt_trip |=> (cause_wdt && core_rst && !in_startup));

  assert_supply_clk_R6: assert property (@(posedge clk) disable iff (!arst_n)
    supply_trip |=> (!clk_sel_ext && !xosc_en_o));

  assert_clk_hold_R7: assert property (@(posedge clk) disable iff (!arst_n)
    (!supply_trip && !cfg_wr && !susp_enter) |=> $stable(clk_sel_ext));

endmodule

bind supply_reset_seq rs_checker u_rs_checker (
  .clk         (clk),
  .arst_n      (arst_n),
  .core_rst    (core_rst),
  .suspend_i   (suspend_i),
  .wdt_req     (wdt_req),
  .cfg_wr      (cfg_wr),
  .bo_s        (bo_s),
  .supply_trip (supply_trip),
  .wdt_trip    (wdt_trip),
  .susp_enter  (susp_enter),
  .in_run      (in_run),
  .in_startup  (in_startup),
  .in_wdt      (in_wdt),
  .lvd_dis_o   (lvd_dis_o),
  .xosc_en_o   (xosc_en_o),
  .clk_sel_ext (clk_sel_ext),
  .cause_wdt   (cause_wdt)
);

// File: tb/test_supply_reset_seq.sv
module test_supply_reset_seq;

  localparam int CLK_PERIOD = 10;
  localparam int S_CYC = 8;
  localparam int W_CYC = 4;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic lv = 1'b0, bo = 1'b0, wdt = 1'b0, susp = 1'b0;
  logic cfg_wr = 1'b0, stat_wr = 1'b0;
  logic [1:0] cfg_wdata = 2'b00, stat_wdata = 2'b00;
  logic core_rst, pin_hiz, clk_sel_ext, xosc_en_o, lvd_dis_o, cause_supply, cause_wdt;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_reset_seq #(.STARTUP_CYC(S_CYC), .WDT_HOLD_CYC(W_CYC)) i_supply_reset_seq (
    .clk(clk), .arst_n(arst_n), .lv_low_raw(lv), .bo_low_raw(bo), .wdt_req(wdt),
    .suspend_i(susp), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .core_rst(core_rst), .pin_hiz(pin_hiz),
    .clk_sel_ext(clk_sel_ext), .xosc_en_o(xosc_en_o), .lvd_dis_o(lvd_dis_o),
    .cause_supply(cause_supply), .cause_wdt(cause_wdt)
  );

  // stimulus: lv, bo, suspend, wdt pulse, monitor disable written first;
  // expected after three edges: core_rst, cause_supply, cause_wdt, lvd_dis_o
  typedef struct packed {
    logic lv; logic bo; logic su; logic wd; logic dis;
    logic e_rst; logic e_cs; logic e_cw; logic e_dis;
  } vec_t;

  localparam vec_t VT [7] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0,  1'b1, 1'b1, 1'b0, 1'b0},  // R2 monitored low supply
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1,  1'b0, 1'b0, 1'b0, 1'b1},  // R2 R10 monitor disabled
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0,  1'b0, 1'b0, 1'b0, 1'b0},  // R2 masked in suspend
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1,  1'b1, 1'b1, 1'b0, 1'b0},  // R3 brown-out re-enables
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0,  1'b1, 1'b1, 1'b0, 1'b0},  // R3 brown-out in suspend
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0,  1'b1, 1'b0, 1'b1, 1'b0},  // R5 watchdog
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1,  1'b1, 1'b0, 1'b1, 1'b1}   // R5 watchdog keeps disable
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // counts rising edges from now until core_rst is seen low (at least three)
  task automatic count_release(output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while ((core_rst || n < 3) && n < 1000);
  endtask

  task automatic wait_run();
    int n;
    n = 0;
    while (core_rst && n < 1000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic cfg_write(input logic [1:0] d);
    cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 core_rst", core_rst, 1);
    chk("R1 pin_hiz", pin_hiz, 1);
    chk("R1 cause_supply", cause_supply, 1);
    chk("R1 cause_wdt", cause_wdt, 0);
    chk("R1 lvd_dis", lvd_dis_o, 0);
    chk("R1 clk_sel_ext", clk_sel_ext, 0);
    chk("R1 xosc_en", xosc_en_o, 0);

    arst_n = 1'b1;
    count_release(n);
    chk("R4 power-up startup length", n, S_CYC + 1);

    foreach (VT[i]) begin
      stat_wr = 1'b1; stat_wdata = 2'b11;
      cfg_wr = 1'b1; cfg_wdata = {1'b0, VT[i].dis};
      susp = VT[i].su;
      @(negedge clk);
      stat_wr = 1'b0; cfg_wr = 1'b0;
      lv = VT[i].lv; bo = VT[i].bo; wdt = VT[i].wd;
      @(negedge clk);
      wdt = 1'b0;
      repeat (2) @(negedge clk);
      chk($sformatf("R2/R3/R5 entry %0d core_rst", i), core_rst, VT[i].e_rst);
      chk($sformatf("R8 entry %0d pin_hiz", i), pin_hiz, VT[i].e_rst);
      chk($sformatf("R2/R3 entry %0d cause_supply", i), cause_supply, VT[i].e_cs);
      chk($sformatf("R5 entry %0d cause_wdt", i), cause_wdt, VT[i].e_cw);
      chk($sformatf("R3/R10 entry %0d lvd_dis", i), lvd_dis_o, VT[i].e_dis);
      lv = 1'b0; bo = 1'b0;
      repeat (3) @(negedge clk);
      susp = 1'b0;
      cfg_write(2'b00);
      wait_run();
      @(negedge clk);
    end

    // R5 watchdog hold length, no startup delay
    wdt = 1'b1;
    @(negedge clk);
    wdt = 1'b0;
    count_release(n);
    chk("R5 watchdog hold length", n, W_CYC);

    // R3 R4 brown-out re-enables monitor; hold until low supply clears
    cfg_write(2'b01);
    bo = 1'b1; lv = 1'b1;
    repeat (5) @(negedge clk);
    bo = 1'b0;
    repeat (8) @(negedge clk);
    chk("R4 held while low supply", core_rst, 1);
    chk("R3 monitor re-enabled", lvd_dis_o, 0);
    lv = 1'b0;
    count_release(n);
    chk("R4 release after brown-out", n, S_CYC + 3);

    // R4 fault during startup restarts the full delay
    lv = 1'b1;
    repeat (4) @(negedge clk);
    lv = 1'b0;
    repeat (5) @(negedge clk);
    chk("R4 in startup delay", core_rst, 1);
    lv = 1'b1;
    repeat (4) @(negedge clk);
    lv = 1'b0;
    count_release(n);
    chk("R4 restarted delay", n, S_CYC + 3);

    // R2 monitor restored when suspend ends
    susp = 1'b1; lv = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 masked in suspend", core_rst, 0);
    susp = 1'b0;
    @(negedge clk);
    chk("R2 restored after suspend", core_rst, 1);
    lv = 1'b0;
    wait_run();

    // R6 R7 clock source handling
    cfg_write(2'b10);
    chk("R6 write selects external", clk_sel_ext, 1);
    chk("R10 xosc bit written", xosc_en_o, 1);
    wdt = 1'b1;
    @(negedge clk);
    wdt = 1'b0;
    chk("R7 watchdog clears enable", xosc_en_o, 0);
    chk("R7 clock kept on watchdog", clk_sel_ext, 1);
    wait_run();
    chk("R7 clock kept after release", clk_sel_ext, 1);
    susp = 1'b1;
    @(negedge clk);
    chk("R7 suspend applies clock", clk_sel_ext, 0);
    susp = 1'b0;
    @(negedge clk);
    cfg_write(2'b10);
    chk("R6 external again", clk_sel_ext, 1);
    lv = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 supply reset core_rst", core_rst, 1);
    chk("R6 supply clears clock", clk_sel_ext, 0);
    chk("R6 supply clears enable", xosc_en_o, 0);
    lv = 1'b0;
    wait_run();

    // R9 write-one-to-clear and set priority
    stat_wr = 1'b1; stat_wdata = 2'b01;
    @(negedge clk);
    stat_wr = 1'b0;
    chk("R9 supply cause cleared", cause_supply, 0);
    chk("R9 watchdog cause kept", cause_wdt, 1);
    stat_wr = 1'b1; stat_wdata = 2'b10; wdt = 1'b1;
    @(negedge clk);
    stat_wr = 1'b0; wdt = 1'b0;
    chk("R9 set wins over clear", cause_wdt, 1);
    wait_run();
    stat_wr = 1'b1; stat_wdata = 2'b10;
    @(negedge clk);
    stat_wr = 1'b0;
    chk("R9 watchdog cause cleared", cause_wdt, 0);
    chk("R9 supply cause untouched", cause_supply, 0);

    finish_run();
  end

endmodule